// File: doc/BRIEF.md
# Serial Link Adaptor Host Register Interface

This block lets a byte-wide microprocessor bus talk to a bit-serial point-to-point link. The host selects the block with an active-low select strobe, two register-address lines and a read/not-write line. Through that bus it reaches four things:

- a received-byte register, which the host can only read;
- a transmit-byte register, which the host can only write;
- a receive status register;
- a transmit status register.

On the link side the block receives finished bytes from a receiver. It hands bytes to a transmitter and asks the transmitter to send an acknowledge packet. The serial timing lives outside this block.

Flow control is paced by the host. A received byte is acknowledged to the far end only when the host reads it. The transmit side becomes ready again only when the transmitter reports that the byte went out and the remote acknowledge came back. Each of the two level interrupts is the AND of a status flag and an enable bit that software can write.

The bus strobes are asynchronous to the system clock. They pass through a two-flop synchroniser. A small state machine then runs exactly one register access per select-low pulse:

- **ST_IDLE**: waits for select to go low. On the synchronised falling edge it moves to **ST_READ** if the latched read line is high, and to **ST_WRITE** if it is low. A read takes effect on that edge.
- **ST_READ**: drives the read value and raises the drive-enable output.
- **ST_WRITE**: waits. On the synchronised rising edge of select the write is committed, using the bus data sampled in the last clock cycle that select was still low.
- Both **ST_READ** and **ST_WRITE** return to **ST_IDLE** on the synchronised rising edge of select.

Top module: `lnkb_regif`

## Requirements
- R1: The access code is {addr[1], addr[0], rd}. 001 reads the received byte. 010 writes the transmit byte. 101 reads receive status. 100 writes receive status. 111 reads transmit status. 110 writes transmit status. 000 and 011 are invalid.
- R2: Each select-low pulse performs exactly one access, however long the pulse lasts. Address and rd are taken at the falling edge of select. Write data is taken at the rising edge of select.
- R3: `bus_oe` is high only during a read access, that is while select is low with rd latched high. Whenever `bus_oe` is low, `bus_rdata` is 0x00.
- R4: In each status register, bit 0 is the flag and bit 1 is the interrupt enable. Bits 7:2 read back the value last written to them. The flag bit cannot be changed by a write.
- R5: `irq_in` equals receive flag AND receive enable, and `irq_out` equals transmit flag AND transmit enable. Clearing an enable drops its interrupt. Setting the enable again while the flag is still set raises the interrupt again.
- R6: A `rx_valid` pulse stores `rx_byte` and sets the receive flag. Only a read of the received byte clears the flag. That read issues a single one-cycle `ack_req` pulse, but only if the flag was set.
- R7: A write of the transmit byte presents the byte on `tx_byte`, pulses `tx_start` for one cycle and clears the transmit flag. A `tx_done` pulse sets the flag again.
- R8: After reset the receive flag, both enables and both interrupts are 0, the transmit flag is 1, and `bus_oe` is 0.
- R9: Writes with the invalid code 000 have no effect. A read of the transmit byte code returns 0x00.
- R10: A read with the invalid code 011 returns 0x00 and has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Active-low select strobe, asynchronous |
| bus_addr | input | 2 | Register address, asynchronous |
| bus_rd | input | 1 | High for read, low for write, asynchronous |
| bus_wdata | input | 8 | Write data from the host |
| bus_rdata | output | 8 | Read data to the host |
| bus_oe | output | 1 | Enable for the external data-bus driver |
| rx_valid | input | 1 | One-cycle pulse: a received byte is ready |
| rx_byte | input | 8 | Received byte |
| ack_req | output | 1 | One-cycle request to send an acknowledge packet |
| tx_start | output | 1 | One-cycle request to transmit `tx_byte` |
| tx_byte | output | 8 | Byte to transmit |
| tx_done | input | 1 | One-cycle pulse: byte sent and remote acknowledge received |
| irq_in | output | 1 | Receive interrupt level |
| irq_out | output | 1 | Transmit interrupt level |

## Verification
Wrong internal state in this block shows at the ports within one host access. A flag left stuck shows up as a wrong bit 0 in the next status read. It also shows up as an interrupt that stays high after its enable is set, or one that never comes. A state machine that fires an access twice per pulse shows as an extra `ack_req` or `tx_start` pulse within a few cycles of the select edge. The bench counts those pulses against the number of accesses it made. It sweeps byte values through both data paths and runs every access code, so a mis-decoded code or a lost byte shows in the very next read.

// File: rtl/lnkb_pkg.sv
package lnkb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } lnkb_state_e;

    localparam logic [1:0] A_DATA_IN  = 2'b00;
    localparam logic [1:0] A_DATA_OUT = 2'b01;
    localparam logic [1:0] A_STAT_IN  = 2'b10;
    localparam logic [1:0] A_STAT_OUT = 2'b11;
endpackage

// File: rtl/lnkb_sync.sv
module lnkb_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= INIT;
            q    <= INIT;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/lnkb_status.sv
module lnkb_status #(
    parameter int  DW       = 8,
    parameter logic FLAG_RST = 1'b0,
    localparam int HW       = DW - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_i,
    input  logic          clr_i,
    input  logic          wr_i,
    input  logic [DW-1:1] wdata_i,
    output logic          flag_o,
    output logic          ie_o,
    output logic [HW-1:0] hi_o,
    output logic          irq_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= FLAG_RST;
            ie_o   <= 1'b0;
            hi_o   <= '0;
        end else begin
            if (set_i)
                flag_o <= 1'b1;
            else if (clr_i)
                flag_o <= 1'b0;
            if (wr_i) begin
                ie_o <= wdata_i[1];
                hi_o <= wdata_i[DW-1:2];
            end
        end
    end

    assign irq_o = flag_o & ie_o;
endmodule

// File: rtl/lnkb_regif.sv
module lnkb_regif
    import lnkb_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_oe,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    output logic          ack_req,
    output logic          tx_start,
    output logic [DW-1:0] tx_byte,
    input  logic          tx_done,
    output logic          irq_in,
    output logic          irq_out
);
    localparam int SW = 1 + AW + 1 + DW;
    localparam int HW = DW - 2;

    logic [SW-1:0] sync_q;
    logic          sel_s, sel_d, rd_s;
    logic [AW-1:0] addr_s, acc_addr;
    logic [DW-1:0] wdata_s, wd_hold, in_data, rd_val;
    logic          fall_det, rise_det;
    logic          do_rd, do_wr;
    logic          rd_data_stb, wr_data_stb, wr_in_stb, wr_out_stb;
    logic          in_flag, in_ie, out_flag, out_ie;
    logic [HW-1:0] in_hi, out_hi;
    lnkb_state_e   state, state_nx;

    lnkb_sync #(.W(SW), .INIT({1'b1, {(SW-1){1'b0}}})) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({bus_sel_n, bus_addr, bus_rd, bus_wdata}),
        .q    (sync_q)
    );
    assign {sel_s, addr_s, rd_s, wdata_s} = sync_q;

    assign fall_det = sel_d & ~sel_s;
    assign rise_det = ~sel_d & sel_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next state and access strobes
    always_comb begin
        state_nx = state;
        do_rd    = 1'b0;
        do_wr    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (fall_det) begin
                    state_nx = rd_s ? ST_READ : ST_WRITE;
                    do_rd    = rd_s;
                end
            end
            ST_READ: begin
                if (rise_det) state_nx = ST_IDLE;
            end
            ST_WRITE: begin
                if (rise_det) begin
                    state_nx = ST_IDLE;
                    do_wr    = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign rd_data_stb = do_rd && (addr_s == A_DATA_IN);
    assign wr_data_stb = do_wr && (acc_addr == A_DATA_OUT);
    assign wr_in_stb   = do_wr && (acc_addr == A_STAT_IN);
    assign wr_out_stb  = do_wr && (acc_addr == A_STAT_OUT);

    always_comb begin
        unique case (addr_s)
            A_DATA_IN:  rd_val = in_data;
            A_STAT_IN:  rd_val = {in_hi, in_ie, in_flag};
            A_STAT_OUT: rd_val = {out_hi, out_ie, out_flag};
            default:    rd_val = '0;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_d     <= 1'b1;
            acc_addr  <= '0;
            wd_hold   <= '0;
            in_data   <= '0;
            bus_rdata <= '0;
            bus_oe    <= 1'b0;
            ack_req   <= 1'b0;
            tx_start  <= 1'b0;
            tx_byte   <= '0;
        end else begin
            sel_d    <= sel_s;
            ack_req  <= rd_data_stb & in_flag;
            tx_start <= wr_data_stb;
            if (!sel_s)
                wd_hold <= wdata_s;
            if (fall_det && state == ST_IDLE)
                acc_addr <= addr_s;
            if (rx_valid)
                in_data <= rx_byte;
            if (wr_data_stb)
                tx_byte <= wd_hold;
            if (do_rd) begin
                bus_rdata <= rd_val;
                bus_oe    <= 1'b1;
            end else if (state_nx == ST_IDLE) begin
                bus_rdata <= '0;
                bus_oe    <= 1'b0;
            end
        end
    end

    lnkb_status #(.DW(DW), .FLAG_RST(1'b0)) u_stat_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (rx_valid),
        .clr_i  (rd_data_stb),
        .wr_i   (wr_in_stb),
        .wdata_i(wd_hold[DW-1:1]),
        .flag_o (in_flag),
        .ie_o   (in_ie),
        .hi_o   (in_hi),
        .irq_o  (irq_in)
    );

    lnkb_status #(.DW(DW), .FLAG_RST(1'b1)) u_stat_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (tx_done),
        .clr_i  (wr_data_stb),
        .wr_i   (wr_out_stb),
        .wdata_i(wd_hold[DW-1:1]),
        .flag_o (out_flag),
        .ie_o   (out_ie),
        .hi_o   (out_hi),
        .irq_o  (irq_out)
    );
endmodule

// File: rtl/lnkb_regif_chk.sv
module lnkb_regif_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel_n,
    input logic          bus_oe,
    input logic [DW-1:0] bus_rdata,
    input logic          ack_req,
    input logic          tx_start,
    input logic          irq_in,
    input logic          irq_out,
    input logic          in_flag,
    input logic          rd_data_stb
);
    p_oe_after_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(bus_sel_n, 3) == 1'b0);

    p_idle_bus_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> bus_rdata == '0);

    p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> !ack_req);

    p_present_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_flag) |-> $past(rd_data_stb));

    p_tx_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    p_start_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !irq_out);

    p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_in && !irq_out && !bus_oe));
endmodule

bind lnkb_regif lnkb_regif_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel_n  (bus_sel_n),
    .bus_oe     (bus_oe),
    .bus_rdata  (bus_rdata),
    .ack_req    (ack_req),
    .tx_start   (tx_start),
    .irq_in     (irq_in),
    .irq_out    (irq_out),
    .in_flag    (in_flag),
    .rd_data_stb(rd_data_stb)
);

// File: tb/lnkb_regif_bench.sv
module lnkb_regif_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel_n = 1'b1;
    logic [1:0] bus_addr = 2'b00;
    logic       bus_rd = 1'b1;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       bus_oe;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       ack_req, tx_start, tx_done = 1'b0;
    logic [7:0] tx_byte;
    logic       irq_in, irq_out;

    int checks = 0;
    int failures = 0;
    int ack_cnt = 0;
    int start_cnt = 0;
    logic [7:0] last_tx = 8'h00;

    always #2.5 clk = ~clk;

    lnkb_regif u_lnkb_regif (
        .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_oe(bus_oe), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .ack_req(ack_req), .tx_start(tx_start), .tx_byte(tx_byte),
        .tx_done(tx_done), .irq_in(irq_in), .irq_out(irq_out)
    );

    always @(posedge clk) begin
        if (ack_req) ack_cnt <= ack_cnt + 1;
        if (tx_start) begin
            start_cnt <= start_cnt + 1;
            last_tx   <= tx_byte;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [1:0] a, input int hold, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_sel_n = 1'b0;
        repeat (hold) @(negedge clk);
        d = bus_rdata;
        check("R3 oe during read", int'(bus_oe), 1);
        bus_sel_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R3 oe after read", int'(bus_oe), 0);
        check("R3 rdata idle", int'(bus_rdata), 0);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b0; bus_wdata = v;
        @(negedge clk);
        bus_sel_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R3 oe during write", int'(bus_oe), 0);
        bus_sel_n = 1'b1;
        repeat (6) @(negedge clk);
        bus_wdata = 8'h00;
    endtask

    task automatic rx_push(input logic [7:0] v);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = v;
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic tx_ack();
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int a0, s0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 irq_in", int'(irq_in), 0);
        check("R8 irq_out", int'(irq_out), 0);
        check("R8 oe", int'(bus_oe), 0);
        bus_read(2'b11, 6, d); check("R8 out status", int'(d), 8'h01);
        bus_read(2'b10, 6, d); check("R8 in status", int'(d), 8'h00);

        // R6 read with nothing present gives no ack
        a0 = ack_cnt;
        bus_read(2'b00, 6, d);
        check("R6 no ack when empty", ack_cnt, a0);

        // R1 R6 receive sweep
        for (int b = 0; b < 256; b += 15) begin
            rx_push(8'(b));
            bus_read(2'b10, 6, d); check("R6 present set", int'(d[0]), 1);
            a0 = ack_cnt;
            bus_read(2'b00, 6, d); check("R1 read data", int'(d), b);
            check("R6 one ack", ack_cnt, a0 + 1);
            bus_read(2'b10, 6, d); check("R6 present clear", int'(d[0]), 0);
        end

        // R2 long select pulse: one access only
        rx_push(8'hC3);
        a0 = ack_cnt;
        bus_read(2'b00, 40, d);
        check("R2 long pulse data", int'(d), 8'hC3);
        check("R2 long pulse one ack", ack_cnt, a0 + 1);

        // R4 bits 7:2 read back, flag bit write ignored
        bus_write(2'b10, 8'hA5);
        bus_read(2'b10, 6, d); check("R4 in status readback", int'(d), 8'hA4);
        bus_write(2'b11, 8'h58);
        bus_read(2'b11, 6, d); check("R4 out status readback", int'(d), 8'h59);

        // R5 interrupt enable dynamics
        bus_write(2'b10, 8'h02);
        check("R5 irq_in no data", int'(irq_in), 0);
        rx_push(8'h3C);
        check("R5 irq_in set", int'(irq_in), 1);
        bus_write(2'b10, 8'h00);
        check("R5 irq_in disabled", int'(irq_in), 0);
        bus_write(2'b10, 8'h02);
        check("R5 irq_in re-enabled", int'(irq_in), 1);

        // R9 R10 invalid codes
        bus_write(2'b00, 8'hFF);
        bus_read(2'b10, 6, d); check("R9 invalid write no effect", int'(d), 8'h03);
        a0 = ack_cnt;
        bus_read(2'b01, 6, d); check("R10 invalid read zero", int'(d), 0);
        check("R10 no side effect", int'(irq_in), 1);
        check("R10 no ack", ack_cnt, a0);
        bus_read(2'b00, 6, d); check("R5 data read", int'(d), 8'h3C);
        check("R5 irq_in drops on read", int'(irq_in), 0);
        check("R9 invalid write kept data", ack_cnt, a0 + 1);

        // R7 transmit sweep
        bus_write(2'b11, 8'h02);
        check("R5 irq_out enabled", int'(irq_out), 1);
        for (int b = 1; b < 256; b += 23) begin
            s0 = start_cnt;
            bus_write(2'b01, 8'(b));
            check("R7 one start", start_cnt, s0 + 1);
            check("R7 tx byte", int'(last_tx), b);
            check("R7 irq_out low while busy", int'(irq_out), 0);
            bus_read(2'b11, 6, d); check("R7 ready cleared", int'(d), 8'h02);
            bus_read(2'b01, 6, d); check("R9 out data reads zero", int'(d), 0);
            tx_ack();
            check("R7 irq_out after ack", int'(irq_out), 1);
        end
        bus_write(2'b11, 8'h00);
        check("R5 irq_out disabled", int'(irq_out), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule